// File: doc/BRIEF.md
# Printer-Port Register Bridge to a Serial Card Link

This block answers a small window of the I/O space on an 8-bit peripheral bus as if it were a printer-port register set. Software uses it as a bit-banged serial link to a memory card. Writing the data register sets three serial output pins directly: data-out, clock and an active-low card select. Reading the status register samples the card's serial data-in pin and returns it spread over the whole byte. A control register can be written and read back, but it drives nothing.

Bus strobes are sampled on the block clock. A write is committed when its strobe ends, and the pins follow one clock later. A read returns its byte one clock after the strobe is first seen low. Any cycle made while the address-enable input is high, for example a DMA cycle, is invisible to the block.

Top module: `pport_sdlink`

## Requirements
- R1: The window is hit when address bits [11:3] equal 9'h06F, which covers 0x378 to 0x37F, whatever bits [15:12] hold. io_hit is high while io_aen is low, the address is in the window and either strobe is low.
- R2: While io_aen is high, io_hit stays low. A read returns 0x00 and a write changes no register and no pin.
- R3: Offset 0 (address bits [2:0]) reads back the data register, offset 2 reads the control register and offsets 3 to 7 read 0xFF. io_rdata carries the value at the first clock edge after io_rd_n is sampled low. It is 0x00 after any edge that sees no decoded read.
- R4: After reset, the data register is 0x00, control is 0xEC and status holds 0x6F. The pins are mosi=0, sclk=0 and cs_n=0.
- R5: Data register bit 0 drives card_mosi, bit 1 drives card_sclk and bit 2 drives card_cs_n. The pins change at the clock edge after the edge that commits a data write, and they stay unchanged until the next data write.
- R6: A read at offset 1 loads the status register with 0xFF if card_miso is high and 0x00 if it is low, sampled at the same edge. The loaded value is returned.
- R7: Writes to offset 1 and to offsets 3 to 7 change no register and no pin.
- R8: Write data and address are taken from the last clock edge at which io_wr_n is sampled low. The write commits at the first edge that samples io_wr_n high again.
- R9: A read of the data register made at the same edge that commits a data write returns the value held before the write. The new value is returned from the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O address |
| io_aen | input | 1 | Address enable; high marks a cycle the block must ignore |
| io_rd_n | input | 1 | Active-low I/O read strobe |
| io_wr_n | input | 1 | Active-low I/O write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| io_hit | output | 1 | Window decode hit for the current strobe |
| card_mosi | output | 1 | Serial data to the card |
| card_sclk | output | 1 | Serial clock to the card |
| card_cs_n | output | 1 | Active-low card select |
| card_miso | input | 1 | Serial data from the card |

## Verification
A data-register write can commit at the same edge that a read of that register is sampled. The bench provokes this by raising the write strobe and lowering the read strobe in the same half cycle. It expects the old byte at that edge and the new byte one edge later, with the pins switching one edge after the commit. Around this collision, the bench sweeps the window aliases, every offset and the neighbouring addresses, checks the pin mapping for every value of the low three data bits, and reads status with both levels of the card input.

// File: rtl/pport_pkg.sv
package pport_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int OFS_W  = 3;
    localparam int WIN_HI = 11;

    localparam logic [ADDR_W-1:0] BASE_ADDR = 16'h0378;

    localparam logic [DATA_W-1:0] DATA_RST = 8'h00;
    localparam logic [DATA_W-1:0] STAT_RST = 8'h6F;
    localparam logic [DATA_W-1:0] CTRL_RST = 8'hEC;
    localparam logic [DATA_W-1:0] OPEN_BUS = 8'hFF;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_STAT = 2'd2,
        SEL_CTRL = 2'd3
    } pport_sel_e;

    typedef struct packed {
        logic              valid;
        pport_sel_e        sel;
        logic [DATA_W-1:0] data;
    } pport_cmt_t;

    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic mosi;
    } pport_pins_t;

    function automatic logic win_match(input logic [ADDR_W-1:0] a);
        return a[WIN_HI:OFS_W] == BASE_ADDR[WIN_HI:OFS_W];
    endfunction

    function automatic pport_sel_e ofs_sel(input logic [OFS_W-1:0] o);
        case (o)
            3'd0:    return SEL_DATA;
            3'd1:    return SEL_STAT;
            3'd2:    return SEL_CTRL;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pport_decode.sv
module pport_decode
    import pport_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              aen,
    input  logic              rd_n,
    input  logic              wr_n,
    output logic              in_win,
    output pport_sel_e        sel,
    output logic              hit
);

    always_comb begin
        in_win = win_match(addr) && !aen;
        sel    = ofs_sel(addr[OFS_W-1:0]);
        hit    = in_win && (!rd_n || !wr_n);
    end

endmodule

// File: rtl/pport_wcap.sv
module pport_wcap
    import pport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_n,
    input  logic              in_win,
    input  pport_sel_e        sel,
    input  logic [DATA_W-1:0] wdata,
    output pport_cmt_t        cmt
);

    logic              wr_q;
    logic              ok_q;
    pport_sel_e        sel_q;
    logic [DATA_W-1:0] dat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= 1'b1;
            ok_q  <= 1'b0;
            sel_q <= SEL_NONE;
            dat_q <= '0;
        end else begin
            wr_q <= wr_n;
            if (!wr_n) begin
                ok_q  <= in_win;
                sel_q <= sel;
                dat_q <= wdata;
            end
        end
    end

    always_comb begin
        cmt.valid = wr_n && !wr_q && ok_q;
        cmt.sel   = sel_q;
        cmt.data  = dat_q;
    end

    AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (rst)
        cmt.valid |=> !cmt.valid); // R8

    AST_COMMIT_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
        cmt.valid |-> $past(!wr_n)); // R8

endmodule

// File: rtl/pport_regs.sv
module pport_regs
    import pport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pport_cmt_t        cmt,
    input  logic              rd_n,
    input  logic              in_win,
    input  pport_sel_e        sel,
    input  logic              miso,
    output logic [DATA_W-1:0] data_reg,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] ctrl_reg;
    logic [DATA_W-1:0] stat_reg;
    logic [DATA_W-1:0] stat_new;
    logic [DATA_W-1:0] rd_mux;
    logic              rd_go;

    always_comb begin
        rd_go    = !rd_n && in_win;
        stat_new = {DATA_W{miso}};
        case (sel)
            SEL_DATA: rd_mux = data_reg;
            SEL_STAT: rd_mux = stat_new;
            SEL_CTRL: rd_mux = ctrl_reg;
            default:  rd_mux = OPEN_BUS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_reg <= DATA_RST;
            ctrl_reg <= CTRL_RST;
            stat_reg <= STAT_RST;
            rdata    <= '0;
        end else begin
            if (cmt.valid && cmt.sel == SEL_DATA) data_reg <= cmt.data;
            if (cmt.valid && cmt.sel == SEL_CTRL) ctrl_reg <= cmt.data;
            if (rd_go && sel == SEL_STAT)         stat_reg <= stat_new;
            rdata <= rd_go ? rd_mux : '0;
        end
    end

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cmt.valid && cmt.sel == SEL_CTRL) |=> $stable(ctrl_reg)); // R7

    AST_STAT_MIRROR: assert property (@(posedge clk) disable iff (rst)
        (rd_go && sel == SEL_STAT) |=> (rdata == {DATA_W{$past(miso)}})); // R6

    AST_STAT_KEEP: assert property (@(posedge clk) disable iff (rst)
        (rd_go && sel == SEL_STAT) |=> (stat_reg == rdata)); // R6

endmodule

// File: rtl/pport_pins.sv
module pport_pins
    import pport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] data_reg,
    output pport_pins_t       pins
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pins <= '{cs_n: DATA_RST[2], sclk: DATA_RST[1], mosi: DATA_RST[0]};
        end else begin
            pins.mosi <= data_reg[0];
            pins.sclk <= data_reg[1];
            pins.cs_n <= data_reg[2];
        end
    end

endmodule

// File: rtl/pport_sdlink.sv
module pport_sdlink
    import pport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_aen,
    input  logic              io_rd_n,
    input  logic              io_wr_n,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              io_hit,
    output logic              card_mosi,
    output logic              card_sclk,
    output logic              card_cs_n,
    input  logic              card_miso
);

    logic              in_win;
    pport_sel_e        sel;
    pport_cmt_t        cmt;
    logic [DATA_W-1:0] data_reg;
    pport_pins_t       pins;
    logic              dat_wr;

    pport_decode u_decode (
        .addr   (io_addr),
        .aen    (io_aen),
        .rd_n   (io_rd_n),
        .wr_n   (io_wr_n),
        .in_win (in_win),
        .sel    (sel),
        .hit    (io_hit)
    );

    pport_wcap u_wcap (
        .clk    (clk),
        .rst    (rst),
        .wr_n   (io_wr_n),
        .in_win (in_win),
        .sel    (sel),
        .wdata  (io_wdata),
        .cmt    (cmt)
    );

    pport_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .cmt      (cmt),
        .rd_n     (io_rd_n),
        .in_win   (in_win),
        .sel      (sel),
        .miso     (card_miso),
        .data_reg (data_reg),
        .rdata    (io_rdata)
    );

    pport_pins u_pins (
        .clk      (clk),
        .rst      (rst),
        .data_reg (data_reg),
        .pins     (pins)
    );

    assign card_mosi = pins.mosi;
    assign card_sclk = pins.sclk;
    assign card_cs_n = pins.cs_n;
    assign dat_wr    = cmt.valid && cmt.sel == SEL_DATA;

    AST_PIN_LAG: assert property (@(posedge clk) disable iff (rst)
        dat_wr |=> ##1 ({card_cs_n, card_sclk, card_mosi} == $past(cmt.data[2:0], 2))); // R5

    AST_PIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(dat_wr, 2) |-> $stable({card_cs_n, card_sclk, card_mosi})); // R5

    AST_AEN_MUTE: assert property (@(posedge clk) disable iff (rst)
        io_aen |=> (io_rdata == '0)); // R2

    AST_WIN_HIT: assert property (@(posedge clk) disable iff (rst)
        (!io_rd_n && !io_aen && io_addr[WIN_HI:OFS_W] == 9'h06F) |-> io_hit); // R1

endmodule

// File: tb/pport_sdlink_bench.sv
module pport_sdlink_bench;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = 16'h0000;
    logic        io_aen = 1'b0;
    logic        io_rd_n = 1'b1;
    logic        io_wr_n = 1'b1;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic        io_hit;
    logic        card_mosi, card_sclk, card_cs_n;
    logic        card_miso = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] exp_data = 8'h00;
    logic [7:0] exp_ctrl = 8'hEC;

    always #(PERIOD/2) clk = ~clk;

    pport_sdlink u_pport_sdlink (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_aen(io_aen),
        .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_hit(io_hit), .card_mosi(card_mosi),
        .card_sclk(card_sclk), .card_cs_n(card_cs_n), .card_miso(card_miso)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pins_chk(input string tag, input logic [7:0] v);
        chk(tag, {29'd0, card_cs_n, card_sclk, card_mosi}, {29'd0, v[2:0]});
    endtask

    task automatic do_read(input logic [15:0] a, output logic [7:0] d, output logic h);
        @(negedge clk);
        io_addr = a; io_rd_n = 1'b0;
        #1 h = io_hit;
        @(negedge clk);
        d = io_rdata;
        io_rd_n = 1'b1;
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] v);
        @(negedge clk);
        io_addr = a; io_wdata = v; io_wr_n = 1'b0;
        @(negedge clk);
        io_wr_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic       h;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R4 reset state
        chk("R4 rdata idle", {24'd0, io_rdata}, 32'h0);
        pins_chk("R4 pins", 8'h00);
        chk("R4 hit idle", {31'd0, io_hit}, 32'd0);
        do_read(16'h037A, d, h);
        chk("R4 control reset", {24'd0, d}, 32'hEC);
        do_read(16'h0378, d, h);
        chk("R4 data reset", {24'd0, d}, 32'h00);
        chk("R1 hit on read", {31'd0, h}, 32'd1);
        @(negedge clk);
        chk("R3 rdata zero after read", {24'd0, io_rdata}, 32'h0);

        // R5 pin mapping and lag for every low-bit pattern
        for (int v = 0; v < 16; v++) begin
            logic [7:0] val;
            logic [7:0] prev;
            val = 8'(v * 37 + 3);
            prev = exp_data;
            @(negedge clk);
            io_addr = 16'h0378; io_wdata = val; io_wr_n = 1'b0;
            #1 chk("R1 hit on write", {31'd0, io_hit}, 32'd1);
            @(negedge clk);
            io_wr_n = 1'b1;
            @(negedge clk);
            pins_chk("R5 pins before lag edge", prev);
            @(negedge clk);
            pins_chk("R5 pins after lag edge", val);
            exp_data = val;
            repeat (2) @(negedge clk);
            pins_chk("R5 pins hold", val);
            do_read(16'h0378, d, h);
            chk("R3 data readback", {24'd0, d}, {24'd0, exp_data});
        end

        // R3 control readback
        for (int v = 0; v < 8; v++) begin
            exp_ctrl = 8'(v * 53 + 17);
            do_write(16'h037A, exp_ctrl);
            do_read(16'h037A, d, h);
            chk("R3 control readback", {24'd0, d}, {24'd0, exp_ctrl});
        end

        // R3 undefined offsets read 0xFF; R7 writes there are ignored
        for (int o = 3; o < 8; o++) begin
            do_read(16'h0378 + 16'(o), d, h);
            chk("R3 open offset", {24'd0, d}, 32'hFF);
            do_write(16'h0378 + 16'(o), 8'h5A);
        end
        do_write(16'h0379, 8'h00);
        do_read(16'h0378, d, h);
        chk("R7 data untouched", {24'd0, d}, {24'd0, exp_data});
        do_read(16'h037A, d, h);
        chk("R7 control untouched", {24'd0, d}, {24'd0, exp_ctrl});
        pins_chk("R7 pins untouched", exp_data);

        // R6 status follows card input
        for (int m = 0; m < 4; m++) begin
            card_miso = m[0];
            do_read(16'h0379, d, h);
            chk("R6 status", {24'd0, d}, m[0] ? 32'hFF : 32'h00);
        end
        card_miso = 1'b0;
        do_write(16'h0379, 8'hFF);
        do_read(16'h0379, d, h);
        chk("R7 status write ignored", {24'd0, d}, 32'h00);

        // R1 aliases on bits [15:12] and neighbour misses
        for (int t = 0; t < 16; t++) begin
            do_read({4'(t), 12'h378}, d, h);
            chk("R1 alias hit", {31'd0, h}, 32'd1);
            chk("R1 alias data", {24'd0, d}, {24'd0, exp_data});
        end
        for (int n = 0; n < 4; n++) begin
            logic [15:0] na;
            na = (n == 0) ? 16'h0370 : (n == 1) ? 16'h0380 : (n == 2) ? 16'h0278 : 16'h0778;
            do_read(na, d, h);
            chk("R1 neighbour miss", {31'd0, h}, 32'd0);
            chk("R3 miss reads zero", {24'd0, d}, 32'h0);
        end

        // R2 address enable high
        io_aen = 1'b1;
        do_read(16'h0378, d, h);
        chk("R2 no hit", {31'd0, h}, 32'd0);
        chk("R2 read zero", {24'd0, d}, 32'h0);
        do_write(16'h0378, ~exp_data);
        do_write(16'h037A, ~exp_ctrl);
        io_aen = 1'b0;
        pins_chk("R2 pins unchanged", exp_data);
        do_read(16'h0378, d, h);
        chk("R2 data unchanged", {24'd0, d}, {24'd0, exp_data});
        do_read(16'h037A, d, h);
        chk("R2 control unchanged", {24'd0, d}, {24'd0, exp_ctrl});

        // R8 last value seen while strobe low is committed
        @(negedge clk);
        io_addr = 16'h0378; io_wdata = 8'h01; io_wr_n = 1'b0;
        @(negedge clk);
        io_wdata = 8'h06;
        @(negedge clk);
        io_wr_n = 1'b1;
        io_wdata = 8'h03;
        repeat (2) @(negedge clk);
        exp_data = 8'h06;
        pins_chk("R8 pins from last low sample", exp_data);
        do_read(16'h0378, d, h);
        chk("R8 data from last low sample", {24'd0, d}, 32'h06);

        // R9 read at the commit edge
        @(negedge clk);
        io_addr = 16'h0378; io_wdata = 8'hC5; io_wr_n = 1'b0;
        @(negedge clk);
        io_wr_n = 1'b1; io_rd_n = 1'b0;
        @(negedge clk);
        chk("R9 old value at commit", {24'd0, io_rdata}, {24'd0, exp_data});
        pins_chk("R9 pins still old", exp_data);
        @(negedge clk);
        chk("R9 new value next edge", {24'd0, io_rdata}, 32'hC5);
        pins_chk("R9 pins new", 8'hC5);
        io_rd_n = 1'b1;
        exp_data = 8'hC5;

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule